// File: doc/BRIEF.md
# Serial Result Port with End-of-Transfer Strobe

This block takes a parallel conversion result and sends it out on a single data-receive line, one bit per shift-clock period, most significant bit first. The parallel side offers a load strobe, the result word and a flag that marks the transfer as secondary communication. An active-low frame-sync output marks each group of bits being shifted. An active-low end-of-receive output marks completion. Its shape depends on a word/byte mode input: a single pulse in word mode, and a level held across the second byte in byte mode. It stays high for secondary transfers.

The word is shifted either as one 16-bit frame or as two 8-bit frames with a one-period gap between them. A request that arrives while a transfer runs is kept in a one-entry hold slot. It starts after the current transfer and its trailing idle period. A separate control bit is registered onto an input-path select output. That output picks the auxiliary or the main analog input pair.

Top module: `serial_result_port`

## Requirements
- R1: A synchronous reset drives rxData, rxFrameN and rxEndN high and inputSel low, and discards any held request, so no transfer starts after reset until a new load strobe arrives.
- R2: A load strobe accepted while idle puts bit 15 on rxData in the period right after the sampling edge; bits 14 down to 0 follow, one per period, and a frame is never low for more than 16 periods in a row.
- R3: rxFrameN is low exactly in the periods that carry a data bit and high in every other period.
- R4: In word mode (byteMode = 0 at the start), rxFrameN is low for 16 periods, and in the next period rxEndN is low for exactly one period while rxFrameN and rxData are high.
- R5: In byte mode (byteMode = 1 at the start), bits 15..8 are sent in 8 periods, then one gap period has rxFrameN high, then bits 7..0 are sent in 8 periods; rxEndN is low from the gap period through the last bit and high afterwards.
- R6: When loadSecondary is 1 at the start of a transfer, rxEndN stays high for the whole transfer; data and frame timing are unchanged.
- R7: A load strobe during a transfer is held and never merged into it; every transfer is followed by one idle period with all three serial outputs high, after which the held request starts.
- R8: The hold slot keeps one request; a newer load strobe that arrives while a request is held replaces it.
- R9: byteMode and loadSecondary are sampled only at the edge that starts a transfer; changes during the transfer have no effect on it.
- R10: inputSel equals auxSelBit one period after it is sampled; 1 selects the auxiliary pair, 0 the main pair.
- R11: rxData is high in every period in which no data bit is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadStrobe | input | 1 | Request to send loadData |
| loadData | input | DATA_W | Conversion result to send |
| loadSecondary | input | 1 | Marks the request as secondary communication |
| byteMode | input | 1 | 1 = two bytes with held end level, 0 = one word with end pulse |
| auxSelBit | input | 1 | Control-register input-select bit |
| rxData | output | 1 | Serial data, MSB first, idle high |
| rxFrameN | output | 1 | Frame sync, active low |
| rxEndN | output | 1 | End-of-receive strobe, active low |
| inputSel | output | 1 | Input-path select, 1 = auxiliary pair |

## Verification
A load accepted at edge k shows its first bit in the period after edge k. A word transfer then runs over periods 0 to 17: bits in periods 0 to 15, the end pulse in period 16 and idle in period 17. A byte transfer puts its gap in period 8, its last bit in period 16 and idle in period 17. inputSel follows its control bit one period after the sampling edge. The bench drives and samples on falling edges and steps a slot-based receiver model once per driven edge. Every period therefore compares the outputs with exactly the slot that edge produced.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // Per-period commands from the sequencer to the datapath.
  typedef struct packed {
    logic capture;    // store loadData in the hold register
    logic loadHold;   // start a transfer from the hold register
    logic loadInput;  // start a transfer straight from loadData
    logic shift;      // present the next bit of the running word
    logic frame;      // frame sync asserted next period
    logic endMark;    // end-of-receive asserted next period
  } srp_strobe_t;

endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        loadStrobe,
  input  logic        loadSecondary,
  input  logic        byteMode,
  output srp_strobe_t strobes
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SLOT_W = $clog2(DATA_W + 2);
  // Slot DATA_W is the word-mode end slot and the last byte-mode bit;
  // slot DATA_W+1 is the trailing idle period.
  localparam logic [SLOT_W-1:0] END_SLOT  = SLOT_W'(DATA_W);
  localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(DATA_W + 1);
  localparam logic [SLOT_W-1:0] GAP_SLOT  = SLOT_W'(HALF_W);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic              curByte;
  logic              curSec;
  logic              pendValid;
  logic              pendSec;

  logic              canStart;
  logic              startNow;
  logic              fromHold;
  logic              captureReq;
  logic              nextBusy;
  logic [SLOT_W-1:0] nextSlot;
  logic              nextByte;
  logic              nextSec;
  logic              nextIsData;
  logic              nextIsEnd;

  always_comb begin
    canStart   = !busy || (slot == IDLE_SLOT);
    startNow   = canStart && (pendValid || loadStrobe);
    fromHold   = startNow && pendValid;
    captureReq = loadStrobe && !(startNow && !pendValid);

    if (startNow) begin
      nextBusy = 1'b1;
      nextSlot = '0;
      nextByte = byteMode;
      nextSec  = fromHold ? pendSec : loadSecondary;
    end else if (busy && (slot != IDLE_SLOT)) begin
      nextBusy = 1'b1;
      nextSlot = slot + 1'b1;
      nextByte = curByte;
      nextSec  = curSec;
    end else begin
      nextBusy = 1'b0;
      nextSlot = '0;
      nextByte = curByte;
      nextSec  = curSec;
    end

    if (nextByte) begin
      nextIsData = (nextSlot < GAP_SLOT) ||
                   ((nextSlot > GAP_SLOT) && (nextSlot <= END_SLOT));
      nextIsEnd  = (nextSlot >= GAP_SLOT) && (nextSlot <= END_SLOT);
    end else begin
      nextIsData = (nextSlot < END_SLOT);
      nextIsEnd  = (nextSlot == END_SLOT);
    end

    strobes.capture   = captureReq;
    strobes.loadHold  = fromHold;
    strobes.loadInput = startNow && !pendValid;
    strobes.shift     = nextBusy && nextIsData && !startNow;
    strobes.frame     = nextBusy && nextIsData;
    strobes.endMark   = nextBusy && nextIsEnd && !nextSec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      slot      <= '0;
      curByte   <= 1'b0;
      curSec    <= 1'b0;
      pendValid <= 1'b0;
      pendSec   <= 1'b0;
    end else begin
      busy    <= nextBusy;
      slot    <= nextSlot;
      curByte <= nextByte;
      curSec  <= nextSec;
      if (captureReq) begin
        pendValid <= 1'b1;
        pendSec   <= loadSecondary;
      end else if (fromHold) begin
        pendValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  srp_strobe_t       strobes,
  input  logic [DATA_W-1:0] loadData,
  input  logic              auxSelBit,
  output logic              rxData,
  output logic              rxFrameN,
  output logic              rxEndN,
  output logic              inputSel
);

  logic [DATA_W-1:0] holdWord;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdWord <= '0;
      shiftReg <= '0;
      rxData   <= 1'b1;
      rxFrameN <= 1'b1;
      rxEndN   <= 1'b1;
      inputSel <= 1'b0;
    end else begin
      if (strobes.capture) begin
        holdWord <= loadData;
      end

      if (strobes.loadHold) begin
        rxData   <= holdWord[DATA_W-1];
        shiftReg <= {holdWord[DATA_W-2:0], 1'b0};
      end else if (strobes.loadInput) begin
        rxData   <= loadData[DATA_W-1];
        shiftReg <= {loadData[DATA_W-2:0], 1'b0};
      end else if (strobes.shift) begin
        rxData   <= shiftReg[DATA_W-1];
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end else begin
        rxData   <= 1'b1;
      end

      rxFrameN <= !strobes.frame;
      rxEndN   <= !strobes.endMark;
      inputSel <= auxSelBit;
    end
  end

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import srp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadStrobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              loadSecondary,
  input  logic              byteMode,
  input  logic              auxSelBit,
  output logic              rxData,
  output logic              rxFrameN,
  output logic              rxEndN,
  output logic              inputSel
);

  srp_strobe_t strobes;

  srp_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .loadStrobe   (loadStrobe),
    .loadSecondary(loadSecondary),
    .byteMode     (byteMode),
    .strobes      (strobes)
  );

  srp_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .loadData (loadData),
    .auxSelBit(auxSelBit),
    .rxData   (rxData),
    .rxFrameN (rxFrameN),
    .rxEndN   (rxEndN),
    .inputSel (inputSel)
  );

endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic rst,
  input logic auxSelBit,
  input logic rxData,
  input logic rxFrameN,
  input logic rxEndN,
  input logic inputSel
);

  localparam int CNT_W = $clog2(DATA_W + 2) + 1;

  logic [CNT_W-1:0] frameRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameRun <= '0;
    end else if (!rxFrameN) begin
      frameRun <= frameRun + 1'b1;
    end else begin
      frameRun <= '0;
    end
  end

  // R2: no frame stays low longer than one word
  always_ff @(posedge clk) begin
    if (!rst) begin
      p_frame_len_r2: assert (rxFrameN || (frameRun < CNT_W'(DATA_W)))
        else $error("frame low for more than DATA_W periods");
    end
  end

  p_idle_high_r1: assert property (@(posedge clk)
    rst |=> (rxData && rxFrameN && rxEndN && !inputSel));

  p_data_idle_r11: assert property (@(posedge clk) disable iff (rst)
    rxFrameN |-> rxData);

  p_end_after_bits_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rxEndN) |-> $past(!rxFrameN));

  p_sel_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (inputSel == $past(auxSelBit)));

endmodule

bind serial_result_port srp_checker #(.DATA_W(DATA_W)) i_srp_checker (
  .clk      (clk),
  .rst      (rst),
  .auxSelBit(auxSelBit),
  .rxData   (rxData),
  .rxFrameN (rxFrameN),
  .rxEndN   (rxEndN),
  .inputSel (inputSel)
);

// File: tb/test_serial_result_port.sv
module test_serial_result_port;

  localparam int W = 16;
  localparam int H = W / 2;
  localparam int IDLE_SLOT = W + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         loadStrobe = 1'b0;
  logic [W-1:0] loadData = '0;
  logic         loadSecondary = 1'b0;
  logic         byteMode = 1'b0;
  logic         auxSelBit = 1'b0;
  logic         rxData;
  logic         rxFrameN;
  logic         rxEndN;
  logic         inputSel;

  always #2 clk = ~clk;

  serial_result_port #(.DATA_W(W)) i_serial_result_port (
    .clk(clk), .rst(rst), .loadStrobe(loadStrobe), .loadData(loadData),
    .loadSecondary(loadSecondary), .byteMode(byteMode), .auxSelBit(auxSelBit),
    .rxData(rxData), .rxFrameN(rxFrameN), .rxEndN(rxEndN), .inputSel(inputSel)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string phase = "";

  // receiver model state
  bit         mBusy = 0;
  int         mSlot = 0;
  bit         mByte = 0;
  bit         mSec = 0;
  logic [W-1:0] mWord = '0;
  bit         mPend = 0;
  logic [W-1:0] mPendWord = '0;
  bit         mPendSec = 0;
  bit         mSel = 0;

  function automatic bit isDataSlot(bit byteM, int s);
    if (byteM) return (s < H) || (s > H && s <= W);
    return s < W;
  endfunction

  function automatic bit isEndSlot(bit byteM, int s);
    if (byteM) return (s >= H) && (s <= W);
    return s == W;
  endfunction

  function automatic logic expBit(bit byteM, int s, logic [W-1:0] word);
    int idx;
    if (!isDataSlot(byteM, s)) return 1'b1;
    idx = (byteM && s > H) ? (W - s) : (W - 1 - s);
    return word[idx];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, phase, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    bit dataSlot = mBusy && isDataSlot(mByte, mSlot);
    bit endSlot  = mBusy && !mSec && isEndSlot(mByte, mSlot);
    logic eBit   = mBusy ? expBit(mByte, mSlot, mWord) : 1'b1;
    check(dataSlot ? "R2" : "R11", rxData, eBit);
    check("R3", rxFrameN, !dataSlot);
    check(mSec ? "R6" : (mByte ? "R5" : "R4"), rxEndN, !endSlot);
    check("R10", inputSel, mSel);
  endtask

  // one driven edge: set inputs, step the model, then sample next period
  task automatic drive(bit l, logic [W-1:0] d, bit s, bit m, bit a);
    bit canStart;
    bit startNow;
    bit capture;
    loadStrobe = l; loadData = d; loadSecondary = s; byteMode = m; auxSelBit = a;
    canStart = !mBusy || (mSlot == IDLE_SLOT);
    startNow = canStart && (mPend || l);
    capture  = l && !(startNow && !mPend);
    if (startNow) begin
      mBusy = 1; mSlot = 0; mByte = m;
      if (mPend) begin mWord = mPendWord; mSec = mPendSec; mPend = 0; end
      else begin mWord = d; mSec = s; end
    end else if (mBusy && mSlot != IDLE_SLOT) begin
      mSlot++;
    end else begin
      mBusy = 0;
    end
    if (capture) begin mPend = 1; mPendWord = d; mPendSec = s; end
    mSel = a;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, loadData, loadSecondary, byteMode, auxSelBit);
  endtask

  task automatic doReset();
    rst = 1'b1;
    loadStrobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mBusy = 0; mSlot = 0; mPend = 0; mSel = 0; mSec = 0; mByte = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: outputs idle after reset
    phase = "R1";
    doReset();
    check("R1", rxData, 1'b1);
    check("R1", rxFrameN, 1'b1);
    check("R1", rxEndN, 1'b1);
    check("R1", inputSel, 1'b0);
    // R1: a request held at reset time is dropped
    drive(1, 16'h1234, 0, 0, 0);
    drive(1, 16'h5678, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mBusy = 0; mSlot = 0; mPend = 0; mSel = 0; mSec = 0; mByte = 0;
    idle(25);

    phase = "R4 word";
    drive(1, 16'hA5C3, 0, 0, 0);
    idle(20);
    phase = "R5 byte";
    drive(1, 16'h3C96, 0, 1, 1);
    idle(20);
    phase = "R6 secondary";
    drive(1, 16'hF00F, 1, 0, 0);
    idle(20);
    drive(1, 16'h0FF0, 1, 1, 0);
    idle(20);

    phase = "R7 held";
    drive(1, 16'h8001, 0, 0, 0);
    idle(4);
    drive(1, 16'h7FFE, 0, 1, 0);
    idle(40);

    phase = "R8 replace";
    drive(1, 16'hAAAA, 0, 0, 1);
    idle(2);
    drive(1, 16'h1111, 1, 0, 1);
    idle(2);
    drive(1, 16'hCCCC, 0, 1, 0);
    idle(40);

    phase = "R9 sampled";
    drive(1, 16'h6A59, 0, 0, 0);
    for (int i = 0; i < 18; i++) drive(0, 16'h0, i[0], !i[0], i[1]);
    drive(1, 16'h9A65, 1, 1, 0);
    for (int i = 0; i < 18; i++) drive(0, 16'h0, !i[0], i[0], i[0]);
    idle(4);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      bit l = ($urandom_range(0, 7) == 0);
      drive(l, W'($urandom), $urandom_range(0, 3) == 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    phase = "back-to-back";
    for (int i = 0; i < 200; i++) drive(1, W'($urandom), i[2], i[3], i[0]);
    idle(40);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule